// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that needs no hardware multiplier. It works in the parallel form of distributed arithmetic. The taps are split into small segments, and each segment has a lookup table of every possible sum of its coefficients. Each table is addressed by one bit taken from each sample in that segment. All bit positions of the input word are looked up in the same cycle. The lookups for one bit position are summed across segments. Each per-bit sum is then scaled by its binary weight and reduced by a registered adder tree. The tree result is rounded and clipped to the output width.

Samples arrive as signed words with a valid strobe. Every accepted sample produces exactly one filtered sample, with a fixed delay. Cycles without the strobe leave the filter history unchanged. The coefficients are parameters, and the tables are computed from them when the design is elaborated.

Top module: `dafir_fir`

## Requirements
- R1: `out_valid` is high exactly 7 clock edges after the edge that accepted a sample with `in_valid` high, and is otherwise low.
- R2: The history advances only on edges where `in_valid` is high. Data present on `in_data` while `in_valid` is low has no effect on any later output.
- R3: Each output is computed from the last 16 accepted samples x[0] (newest) to x[15], all in two's complement. The most significant bit carries weight -2^15. The full-precision result is y = sum c[k]*x[k], and every bit position contributes correctly, including the sign bit.
- R4: With a zeroed history, a single sample of +32767 followed by zeros yields the coefficient list c[0..15] in order, one value per output.
- R5: The output is floor((y + 2^14) / 2^15), so exact halves round toward plus infinity. An impulse of +256 gives 63 on the 8000 tap, and an impulse of -256 gives -62 there.
- R6: Results above +32767 leave as +32767, and results below -32768 leave as -32768.
- R7: Synchronous active-high reset clears the history, drives `out_valid` low and `out_data` to 0, and allows no valid output in the first 7 edges after release.
- R8: With `in_valid` held high, one output is produced per clock, and there are as many outputs as inputs.
- R9: `out_data` keeps its last value on every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Filtered, rounded and saturated sample |

## Verification
The sign-bit path is the hardest part to reach from the ports. Only samples with the top bit set drive the subtracted lookup term, and random data hides a wrong sign among thousands of other terms. The stimulus therefore sends one impulse at each single-bit weight, including -32768, and then sweeps the amplitude across the whole input range in a continuous stream. Exact rounding ties and both saturation limits are reached with chosen impulses and held full-scale inputs. Gaps in the strobe are filled with random data on `in_data` to show that the history ignores it.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    localparam int DATA_W_DEF   = 16;
    localparam int COEF_W_DEF   = 16;
    localparam int NTAPS_DEF    = 16;
    localparam int SEG_TAPS_DEF = 4;
    localparam int OUT_W_DEF    = 16;
    localparam int RSHIFT_DEF   = 15;

    typedef logic [NTAPS_DEF-1:0][COEF_W_DEF-1:0] coef_set_t;

    // Symmetric low-pass set; index 0 multiplies the newest sample.
    function automatic coef_set_t default_coefs();
        coef_set_t c;
        c[0]  = -16'sd300;
        c[1]  = -16'sd800;
        c[2]  =  16'sd0;
        c[3]  =  16'sd1500;
        c[4]  =  16'sd3000;
        c[5]  =  16'sd5500;
        c[6]  =  16'sd8000;
        c[7]  =  16'sd9500;
        c[8]  =  16'sd9500;
        c[9]  =  16'sd8000;
        c[10] =  16'sd5500;
        c[11] =  16'sd3000;
        c[12] =  16'sd1500;
        c[13] =  16'sd0;
        c[14] = -16'sd800;
        c[15] = -16'sd300;
        return c;
    endfunction

    // Register stages from accepted sample to output strobe.
    function automatic int pipe_latency(int data_w);
        return 3 + $clog2(data_w);
    endfunction

endpackage

// File: rtl/dafir_delay_line.sv
module dafir_delay_line #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           shift_en,
    input  logic [DATA_W-1:0]              din,
    output logic [NTAPS-1:0][DATA_W-1:0]   taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
            for (int k = 1; k < NTAPS; k++) begin
                taps[k] <= taps[k-1];
            end
        end
    end

endmodule

// File: rtl/dafir_lut_bank.sv
module dafir_lut_bank #(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int NTAPS    = 16,
    parameter int SEG_TAPS = 4,
    parameter int LUT_W    = 18,
    parameter int PART_W   = 20,
    parameter logic [NTAPS-1:0][COEF_W-1:0] COEFS = '0
) (
    input  logic                           clk,
    input  logic [NTAPS-1:0][DATA_W-1:0]   taps,
    output logic [DATA_W-1:0][PART_W-1:0]  parts
);

    localparam int NSEG  = NTAPS / SEG_TAPS;
    localparam int DEPTH = 1 << SEG_TAPS;

    typedef logic [DEPTH-1:0][LUT_W-1:0] rom_t;

    // Entry a holds the sum of the segment's coefficients selected by the bits of a.
    function automatic rom_t build_rom(int seg);
        rom_t r;
        logic signed [LUT_W-1:0] acc;
        for (int a = 0; a < DEPTH; a++) begin
            acc = '0;
            for (int k = 0; k < SEG_TAPS; k++) begin
                if (a[k]) begin
                    acc = acc + LUT_W'($signed(COEFS[seg*SEG_TAPS+k]));
                end
            end
            r[a] = acc;
        end
        return r;
    endfunction

    logic [NSEG-1:0][DATA_W-1:0][LUT_W-1:0] look;
    logic [DATA_W-1:0][PART_W-1:0]          part_d;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam rom_t ROM = build_rom(g);
        logic [DATA_W-1:0][SEG_TAPS-1:0] seg_addr;
        logic [DATA_W-1:0][LUT_W-1:0]    seg_out;

        always_comb begin
            for (int b = 0; b < DATA_W; b++) begin
                for (int k = 0; k < SEG_TAPS; k++) begin
                    seg_addr[b][k] = taps[g*SEG_TAPS+k][b];
                end
                seg_out[b] = ROM[seg_addr[b]];
            end
        end

        assign look[g] = seg_out;
    end

    always_comb begin
        for (int b = 0; b < DATA_W; b++) begin
            part_d[b] = '0;
            for (int g = 0; g < NSEG; g++) begin
                part_d[b] = part_d[b] + PART_W'($signed(look[g][b]));
            end
        end
    end

    always_ff @(posedge clk) begin
        parts <= part_d;
    end

endmodule

// File: rtl/dafir_adder_tree.sv
module dafir_adder_tree #(
    parameter int DATA_W = 16,
    parameter int PART_W = 20,
    parameter int ACC_W  = 36
) (
    input  logic                          clk,
    input  logic [DATA_W-1:0][PART_W-1:0] parts,
    output logic signed [ACC_W-1:0]       sum
);

    localparam int LVLS = $clog2(DATA_W);
    localparam int NPAD = 1 << LVLS;

    logic signed [ACC_W-1:0] leaf [NPAD];
    logic signed [ACC_W-1:0] node [NPAD-1];

    // Bit-weighted leaves; the top bit position carries a negative weight.
    for (genvar b = 0; b < NPAD; b++) begin : g_leaf
        if (b == DATA_W - 1) begin : g_sign
            assign leaf[b] = -(ACC_W'($signed(parts[b])) <<< b);
        end else if (b < DATA_W) begin : g_mag
            assign leaf[b] = ACC_W'($signed(parts[b])) <<< b;
        end else begin : g_pad
            assign leaf[b] = '0;
        end
    end

    // Heap-ordered tree, one register per level; node i has children 2i+1 and 2i+2.
    for (genvar i = 0; i < NPAD - 1; i++) begin : g_node
        if (2*i + 1 >= NPAD - 1) begin : g_from_leaf
            always_ff @(posedge clk) begin
                node[i] <= leaf[2*i+1-(NPAD-1)] + leaf[2*i+2-(NPAD-1)];
            end
        end else begin : g_from_node
            always_ff @(posedge clk) begin
                node[i] <= node[2*i+1] + node[2*i+2];
            end
        end
    end

    assign sum = node[0];

endmodule

// File: rtl/dafir_fir.sv
module dafir_fir
    import dafir_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int COEF_W   = COEF_W_DEF,
    parameter int NTAPS    = NTAPS_DEF,
    parameter int SEG_TAPS = SEG_TAPS_DEF,
    parameter int OUT_W    = OUT_W_DEF,
    parameter int RSHIFT   = RSHIFT_DEF,
    parameter logic [NTAPS-1:0][COEF_W-1:0] COEFS = default_coefs()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    localparam int NSEG    = NTAPS / SEG_TAPS;
    localparam int LUT_W   = COEF_W + $clog2(SEG_TAPS);
    localparam int PART_W  = LUT_W + $clog2(NSEG);
    localparam int ACC_W   = DATA_W + COEF_W + $clog2(NTAPS);
    localparam int RW      = ACC_W + 1;
    localparam int LATENCY = pipe_latency(DATA_W);

    localparam logic signed [RW-1:0] SAT_HI = (RW'(1) <<< (OUT_W - 1)) - RW'(1);
    localparam logic signed [RW-1:0] SAT_LO = -(RW'(1) <<< (OUT_W - 1));
    localparam logic signed [RW-1:0] HALF   = RW'(1) <<< (RSHIFT - 1);

    logic [NTAPS-1:0][DATA_W-1:0]  taps;
    logic [DATA_W-1:0][PART_W-1:0] parts;
    logic signed [ACC_W-1:0]       tree_sum;
    logic [LATENCY-1:0]            vpipe;
    logic signed [RW-1:0]          rounded;
    logic signed [RW-1:0]          scaled;
    logic [OUT_W-1:0]              clipped;

    dafir_delay_line #(
        .DATA_W (DATA_W),
        .NTAPS  (NTAPS)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_data),
        .taps     (taps)
    );

    dafir_lut_bank #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .NTAPS    (NTAPS),
        .SEG_TAPS (SEG_TAPS),
        .LUT_W    (LUT_W),
        .PART_W   (PART_W),
        .COEFS    (COEFS)
    ) u_luts (
        .clk   (clk),
        .taps  (taps),
        .parts (parts)
    );

    dafir_adder_tree #(
        .DATA_W (DATA_W),
        .PART_W (PART_W),
        .ACC_W  (ACC_W)
    ) u_tree (
        .clk   (clk),
        .parts (parts),
        .sum   (tree_sum)
    );

    // Round half up, then clip to the output range.
    always_comb begin
        rounded = RW'(tree_sum) + HALF;
        scaled  = rounded >>> RSHIFT;
        if (scaled > SAT_HI) begin
            clipped = OUT_W'(SAT_HI);
        end else if (scaled < SAT_LO) begin
            clipped = OUT_W'(SAT_LO);
        end else begin
            clipped = OUT_W'(scaled);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe    <= '0;
            out_data <= '0;
        end else begin
            vpipe <= {vpipe[LATENCY-2:0], in_valid};
            if (vpipe[LATENCY-2]) begin
                out_data <= clipped;
            end
        end
    end

    assign out_valid = vpipe[LATENCY-1];

endmodule

// File: rtl/dafir_checker.sv
module dafir_checker #(
    parameter int LATENCY = 7,
    parameter int OUT_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    logic [LATENCY-1:0] strobe_hist;
    int unsigned        since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_hist <= '0;
            since_rst   <= 0;
        end else begin
            strobe_hist <= {strobe_hist[LATENCY-2:0], in_valid};
            if (since_rst < LATENCY) begin
                since_rst <= since_rst + 1;
            end
        end
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid == strobe_hist[LATENCY-1]);

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_data == '0));

    assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst < LATENCY) |-> !out_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

bind dafir_fir dafir_checker #(
    .LATENCY (LATENCY),
    .OUT_W   (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/dafir_fir_tb.sv
module dafir_fir_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    always #5 clk = ~clk;

    dafir_fir u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int     checks = 0;
    int     fails  = 0;
    string  req    = "R3";
    bit     done   = 1'b0;
    int     cf [16] = '{-300, -800, 0, 1500, 3000, 5500, 8000, 9500,
                        9500, 8000, 5500, 3000, 1500, 0, -800, -300};
    longint hist [16];
    int     expq [$];
    int     cap  [$];
    bit [6:0] ev;
    int     last_out = 0;
    bit [31:0] rs = 32'h1BAD_5EED;

    task automatic chk(string r, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", r, got, exp);
        end
    endtask

    function automatic bit [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic int model_out();
        longint y = 0;
        for (int k = 0; k < 16; k++) y += longint'(cf[k]) * hist[k];
        y = (y + 16384) >>> 15;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        return int'(y);
    endfunction

    function automatic int cap_at(int k);
        if (k < cap.size()) return cap[k];
        return 999999;
    endfunction

    // Reference history, updated at the same edge the design samples.
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) hist[k] = 0;
            ev = '0;
            expq.delete();
        end else begin
            ev = {ev[5:0], in_valid};
            if (in_valid) begin
                for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = longint'($signed(in_data));
                expq.push_back(model_out());
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1", int'(out_valid), int'(ev[6]));
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk(req, int'($signed(out_data)), 999999);
                end else begin
                    chk(req, int'($signed(out_data)), expq.pop_front());
                end
                cap.push_back(int'($signed(out_data)));
                last_out = int'($signed(out_data));
            end else begin
                chk("R9", int'($signed(out_data)), last_out);
            end
        end
    end

    task automatic send(int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(v);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 16'(rnd());
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_out = 0;
        cap.delete();
    endtask

    task automatic impulse(int amp);
        do_reset();
        send(amp);
        for (int i = 0; i < 17; i++) send(0);
        idle(10);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        chk("R7", int'(out_valid), 0);
        chk("R7", int'(out_data), 0);
        rst = 1'b0;
        idle(10);
        chk("R7", int'(out_valid), 0);

        // R4: positive full-scale impulse returns the coefficient list
        req = "R4";
        impulse(32767);
        for (int k = 0; k < 16; k++) chk("R4", cap_at(k), cf[k]);

        // R3: negative full-scale impulse exercises the sign-bit term
        req = "R3";
        impulse(-32768);
        for (int k = 0; k < 16; k++) chk("R3", cap_at(k), -cf[k]);

        // R3: one impulse per bit weight
        for (int b = 0; b < 16; b++) impulse(32'(16'(1 << b)) >= 32768 ? -32768 : (1 << b));

        // R5: exact half ties round upward
        req = "R5";
        impulse(256);
        chk("R5", cap_at(6), 63);
        impulse(-256);
        chk("R5", cap_at(6), -62);

        // R6: held full-scale levels saturate
        req = "R6";
        do_reset();
        for (int i = 0; i < 24; i++) send(32767);
        idle(10);
        chk("R6", cap_at(cap.size() - 1), 32767);
        do_reset();
        for (int i = 0; i < 24; i++) send(-32768);
        idle(10);
        chk("R6", cap_at(cap.size() - 1), -32768);

        // R2: random samples with gaps full of random data
        req = "R2";
        do_reset();
        for (int i = 0; i < 600; i++) begin
            if (rnd() % 2 == 0) send(int'(rnd() % 65536));
            else idle(1 + int'(rnd() % 3));
        end
        idle(10);

        // R8: continuous amplitude sweep, one output per clock
        req = "R8";
        do_reset();
        for (int v = -32768; v < 32768; v += 97) send(v);
        idle(10);
        chk("R8", cap.size(), (65536 + 96) / 97);

        // R8: continuous random stream mixing extremes
        do_reset();
        for (int i = 0; i < 400; i++) begin
            case (rnd() % 4)
                0: send(32767);
                1: send(-32768);
                default: send(int'(rnd() % 65536));
            endcase
        end
        idle(10);
        chk("R8", cap.size(), 400);
        chk("R1", expq.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule